// File: doc/BRIEF.md
# Lockable Byte Register File

This block is a 128-slot, byte-wide register file that sits behind a serial-bus target. The target presents a one-cycle write strobe or read strobe together with an address and write data. Read data is returned combinationally in the same cycle. The protocol engine, the motor hardware and any remote transfer engine are outside the block. The block gives them a one-cycle update strobe, a one-cycle re-enumeration strobe and a level restart request.

Writes are guarded by two code-word locks.

- The master lock opens only while its register holds the master code. It grants write access to almost every register.
- The user lock opens only while its register holds the user code. It grants access only to the drive-level and system-configuration registers.

Two address ranges are reserved holes. Reads there return a filler byte and writes there are dropped. A constant identity byte and a read-only baud byte can never be written. Two saturating diagnostic counters record out-of-range accesses and refused writes.

Top module: `lockreg_file`

## Requirements
- R1: Address 0x01 always reads 0xA9. A write to it leaves that value unchanged.
- R2: The valid addresses are 0x00 to 0x7E. A read of any address from 0x7F to 0xFF returns 0x00.
- R3: Addresses 0x42–0x4F and 0x56–0x6F read 0x55. A write to them is discarded and does not advance either counter.
- R4: The master lock register is at 0x74 and the code that opens it is 0x9B. Writing any other value closes it again.
  - Only while it is open can a write change these registers: 0x00, 0x02–0x0E, 0x11–0x1D, 0x1F and 0x50–0x55.
  - The lock registers 0x74 and 0x75 are always writable.
- R5: The user lock register is at 0x75 and the code that opens it is 0x5C. The registers 0x20–0x41, 0x70–0x73 and 0x76–0x7E are writable while either the user lock or the master lock is open.
- R6: Every read or write strobe at an address of 0x7F or above adds one to the out-of-range counter, which reads at 0x0F.
- R7: Every write refused by a lock, or refused because the target is read-only, adds one to the refused-write counter, which reads at 0x10.
- R8: A permitted write to 0x72 with bit 0 set raises `update_strobe` for exactly the following cycle. Address 0x72 always reads 0x00.
- R9: A permitted write to 0x78 stores the byte.
  - Bit 1 drives `reenum_strobe` for one cycle and then clears itself.
  - Bit 0 drives `restart_req` and holds until it is rewritten.
- R10: Both counters stop at 0xFF instead of wrapping. A write to either counter while the master lock is open clears it to 0x00. Without the master lock, such a write is refused.
- R11: After reset, the registers at 0x74, 0x75, 0x0F and 0x10 all read 0x00.
- R12: Addresses 0x01 and 0x1E are read-only. A write to either is counted as refused whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, same cycle |
| update_strobe | output | 1 | One-cycle request to apply drive levels |
| reenum_strobe | output | 1 | One-cycle re-enumeration request |
| restart_req | output | 1 | Restart request level |

## Verification
The bench builds the block with its default parameters: 8-bit counters, master code 0x9B and user code 0x5C. With these values, the full saturation of the out-of-range counter can be reached in a few hundred read strobes. The bench walks the block through every lock state in turn: locked, user lock only, master lock open, and master lock closed again. It probes both edges of each hole range and the first address past the valid space. It also checks the exact cycle in which each of the two strobes rises and falls.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_ID      = 8'h01;
  localparam logic [ADDR_W-1:0] A_OOR_CNT = 8'h0F;
  localparam logic [ADDR_W-1:0] A_REF_CNT = 8'h10;
  localparam logic [ADDR_W-1:0] A_BAUD    = 8'h1E;
  localparam logic [ADDR_W-1:0] A_FORCE   = 8'h72;
  localparam logic [ADDR_W-1:0] A_MLOCK   = 8'h74;
  localparam logic [ADDR_W-1:0] A_ULOCK   = 8'h75;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h78;
  localparam logic [ADDR_W-1:0] A_LAST    = 8'h7E;

  localparam logic [ADDR_W-1:0] HOLE1_LO = 8'h42;
  localparam logic [ADDR_W-1:0] HOLE1_HI = 8'h4F;
  localparam logic [ADDR_W-1:0] HOLE2_LO = 8'h56;
  localparam logic [ADDR_W-1:0] HOLE2_HI = 8'h6F;

  localparam logic [ADDR_W-1:0] USR1_LO = 8'h20;
  localparam logic [ADDR_W-1:0] USR1_HI = 8'h41;
  localparam logic [ADDR_W-1:0] USR2_LO = 8'h70;

  localparam logic [DATA_W-1:0] ID_VALUE   = 8'hA9;
  localparam logic [DATA_W-1:0] FILL_VALUE = 8'h55;

  typedef enum logic [2:0] {
    CLS_OOR,
    CLS_HOLE,
    CLS_RO,
    CLS_LOCK,
    CLS_CNT,
    CLS_USER,
    CLS_MASTER
  } acc_class_e;
endpackage

// File: rtl/lrf_rst_sync.sv
module lrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/lrf_decode.sv
module lrf_decode
  import lrf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output acc_class_e        cls
);
  always_comb begin
    if (addr > A_LAST)                                   cls = CLS_OOR;
    else if ((addr >= HOLE1_LO && addr <= HOLE1_HI) ||
             (addr >= HOLE2_LO && addr <= HOLE2_HI))     cls = CLS_HOLE;
    else if (addr == A_ID || addr == A_BAUD)             cls = CLS_RO;
    else if (addr == A_MLOCK || addr == A_ULOCK)         cls = CLS_LOCK;
    else if (addr == A_OOR_CNT || addr == A_REF_CNT)     cls = CLS_CNT;
    else if ((addr >= USR1_LO && addr <= USR1_HI) ||
             (addr >= USR2_LO))                          cls = CLS_USER;
    else                                                 cls = CLS_MASTER;
  end
endmodule

// File: rtl/lrf_sat_cnt.sv
module lrf_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX) && !clr |=> cnt_q == MAX); // R10
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clr |=> cnt_q == $past(cnt_q)); // R6
endmodule

// File: rtl/lockreg_file.sv
module lockreg_file
  import lrf_pkg::*;
#(
  parameter int               CNT_W       = 8,
  parameter logic [DATA_W-1:0] MASTER_CODE = 8'h9B,
  parameter logic [DATA_W-1:0] USER_CODE   = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              update_strobe,
  output logic              reenum_strobe,
  output logic              restart_req
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int NSLOTS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] MLOCK_IDX = A_MLOCK[IDX_W-1:0];
  localparam logic [IDX_W-1:0] ULOCK_IDX = A_ULOCK[IDX_W-1:0];
  localparam logic [IDX_W-1:0] CTRL_IDX  = A_CTRL[IDX_W-1:0];
  localparam int REENUM_BIT  = 1;
  localparam int RESTART_BIT = 0;

  logic              rst_sync_n;
  acc_class_e        cls;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mem_q [NSLOTS];
  logic [DATA_W-1:0] mem_d [NSLOTS];
  logic              mem_en;
  logic              master_open;
  logic              user_open;
  logic              wr_allow;
  logic              store_en;
  logic              refuse;
  logic              oor_hit;
  logic              clr_oor;
  logic              clr_ref;
  logic              upd_d;
  logic              upd_q;
  logic [CNT_W-1:0]  oor_cnt;
  logic [CNT_W-1:0]  ref_cnt;

  lrf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lrf_decode u_decode (
    .addr (bus_addr),
    .cls  (cls)
  );

  assign idx = bus_addr[IDX_W-1:0];

  // access permission
  always_comb begin
    master_open = (mem_q[MLOCK_IDX] == MASTER_CODE);
    user_open   = (mem_q[ULOCK_IDX] == USER_CODE);
    unique case (cls)
      CLS_LOCK:   wr_allow = 1'b1;
      CLS_USER:   wr_allow = user_open | master_open;
      CLS_MASTER: wr_allow = master_open;
      CLS_CNT:    wr_allow = master_open;
      default:    wr_allow = 1'b0;
    endcase
    refuse   = bus_wr & ~wr_allow & (cls != CLS_HOLE) & (cls != CLS_OOR);
    oor_hit  = (bus_wr | bus_rd) & (cls == CLS_OOR);
    store_en = bus_wr & wr_allow & (cls != CLS_CNT) & (bus_addr != A_FORCE);
    clr_oor  = bus_wr & wr_allow & (bus_addr == A_OOR_CNT);
    clr_ref  = bus_wr & wr_allow & (bus_addr == A_REF_CNT);
    upd_d    = bus_wr & wr_allow & (bus_addr == A_FORCE) & bus_wdata[0];
  end

  // register storage next state: self-clearing bit first, new write wins
  always_comb begin
    mem_d = mem_q;
    mem_d[CTRL_IDX][REENUM_BIT] = 1'b0;
    if (store_en) mem_d[idx] = bus_wdata;
    mem_en = store_en | mem_q[CTRL_IDX][REENUM_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NSLOTS; i++) mem_q[i] <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) upd_q <= 1'b0;
    else             upd_q <= upd_d;
  end

  lrf_sat_cnt #(.W(CNT_W)) u_oor_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (oor_hit),
    .clr   (clr_oor),
    .cnt   (oor_cnt)
  );

  lrf_sat_cnt #(.W(CNT_W)) u_ref_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (refuse),
    .clr   (clr_ref),
    .cnt   (ref_cnt)
  );

  // read path
  always_comb begin
    if (cls == CLS_OOR)             bus_rdata = '0;
    else if (cls == CLS_HOLE)       bus_rdata = FILL_VALUE;
    else if (bus_addr == A_ID)      bus_rdata = ID_VALUE;
    else if (bus_addr == A_OOR_CNT) bus_rdata = DATA_W'(oor_cnt);
    else if (bus_addr == A_REF_CNT) bus_rdata = DATA_W'(ref_cnt);
    else if (bus_addr == A_FORCE)   bus_rdata = '0;
    else                            bus_rdata = mem_q[idx];
  end

  assign update_strobe = upd_q;
  assign reenum_strobe = mem_q[CTRL_IDX][REENUM_BIT];
  assign restart_req   = mem_q[CTRL_IDX][RESTART_BIT];

  AST_UPD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    update_strobe |-> $past(bus_wr && bus_addr == A_FORCE && bus_wdata[0])); // R8
  AST_REENUM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reenum_strobe && !(store_en && bus_addr == A_CTRL) |=> !reenum_strobe); // R9
  AST_HOLE_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd && cls == CLS_HOLE |-> bus_rdata == FILL_VALUE); // R3
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd && bus_addr == A_ID |-> bus_rdata == ID_VALUE); // R1
endmodule

// File: tb/lockreg_file_tb.sv
module lockreg_file_tb;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       update_strobe;
  logic       reenum_strobe;
  logic       restart_req;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  lockreg_file u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .update_strobe (update_strobe),
    .reenum_strobe (reenum_strobe),
    .restart_req   (restart_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    sb_item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compares read data mid-cycle against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_rd) begin
        if (sb_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL scoreboard: unexpected read, actual 0x%02h expected none", bus_rdata);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          chk(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd(8'h74, 8'h00, "R11 master lock after reset");
    rd(8'h75, 8'h00, "R11 user lock after reset");
    rd(8'h0F, 8'h00, "R11 oor counter after reset");
    rd(8'h10, 8'h00, "R11 refused counter after reset");
    #5 chk("R11 update_strobe idle", {7'd0, update_strobe}, 8'h00);
    chk("R11 restart_req idle", {7'd0, restart_req}, 8'h00);

    // R1 / R12 identity byte
    rd(8'h01, 8'hA9, "R1 identity read");
    wr(8'h01, 8'h33);
    rd(8'h01, 8'hA9, "R1 identity after write");
    rd(8'h10, 8'h01, "R7 R12 identity write refused");

    // R5 user lock
    wr(8'h20, 8'h44);
    rd(8'h20, 8'h00, "R5 drive level locked");
    wr(8'h75, 8'h5C);
    wr(8'h20, 8'h44);
    rd(8'h20, 8'h44, "R5 drive level with user lock open");
    wr(8'h50, 8'h12);
    rd(8'h50, 8'h00, "R4 master-only refused under user lock");

    // R4 master lock
    wr(8'h74, 8'h9B);
    wr(8'h50, 8'h12);
    rd(8'h50, 8'h12, "R4 master-only with master open");
    wr(8'h74, 8'h00);
    wr(8'h50, 8'h77);
    rd(8'h50, 8'h12, "R4 master relocked");
    rd(8'h10, 8'h04, "R7 refused count after lock tests");

    // R3 holes
    wr(8'h45, 8'h99);
    rd(8'h42, 8'h55, "R3 hole1 low");
    rd(8'h45, 8'h55, "R3 hole after write");
    rd(8'h4F, 8'h55, "R3 hole1 high");
    rd(8'h56, 8'h55, "R3 hole2 low");
    rd(8'h6F, 8'h55, "R3 hole2 high");
    rd(8'h41, 8'h00, "R3 below hole1 is storage");
    rd(8'h70, 8'h00, "R3 above hole2 is storage");
    rd(8'h10, 8'h04, "R3 hole write not counted");

    // R2 / R6 out of range
    rd(8'h7F, 8'h00, "R2 first invalid address");
    wr(8'h80, 8'h11);
    rd(8'hFF, 8'h00, "R2 top address");
    rd(8'h7E, 8'h00, "R2 last valid address");
    rd(8'h0F, 8'h03, "R6 oor count");

    // R8 force update
    wr(8'h72, 8'h01);
    #5 chk("R8 update_strobe high", {7'd0, update_strobe}, 8'h01);
    @(negedge clk); #5;
    chk("R8 update_strobe one cycle", {7'd0, update_strobe}, 8'h00);
    rd(8'h72, 8'h00, "R8 force reads zero");
    wr(8'h72, 8'h00);
    #5 chk("R8 no strobe on zero write", {7'd0, update_strobe}, 8'h00);

    // R9 control
    wr(8'h78, 8'h03);
    #5 chk("R9 reenum_strobe high", {7'd0, reenum_strobe}, 8'h01);
    chk("R9 restart_req set", {7'd0, restart_req}, 8'h01);
    @(negedge clk); #5;
    chk("R9 reenum_strobe cleared", {7'd0, reenum_strobe}, 8'h00);
    chk("R9 restart_req holds", {7'd0, restart_req}, 8'h01);
    rd(8'h78, 8'h01, "R9 control readback");

    // R10 / R12 counter clear and read-only baud
    wr(8'h0F, 8'h00);
    rd(8'h0F, 8'h03, "R10 clear refused while locked");
    rd(8'h10, 8'h05, "R7 counter write refused");
    wr(8'h74, 8'h9B);
    wr(8'h0F, 8'h00);
    rd(8'h0F, 8'h00, "R10 oor counter cleared");
    wr(8'h1E, 8'h77);
    rd(8'h1E, 8'h00, "R12 baud unchanged");
    rd(8'h10, 8'h06, "R12 baud refused with master open");
    wr(8'h10, 8'h00);
    rd(8'h10, 8'h00, "R10 refused counter cleared");

    // R10 saturation
    for (int i = 0; i < 260; i++) rd(8'h90, 8'h00, "R2 oor read");
    rd(8'h0F, 8'hFF, "R10 oor saturates");
    rd(8'hC0, 8'h00, "R2 oor read");
    rd(8'h0F, 8'hFF, "R10 oor stays saturated");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule